// File: doc/BRIEF.md
# Monochrome Bitmap Raster Timing Generator

This block drives a monochrome display from a bitmap of 512 by 256 pixels, one bit per pixel, held in an external 16 KiB frame memory. A single 16 MHz clock steps a pixel counter of 1024 clocks per 64 us line and a line counter of 312 lines per non-interlaced 50 Hz field. From these two counters it produces horizontal and vertical sync, a blanking flag and a line-start pulse. During active lines it also issues frame-memory byte reads in order and parallel-loads each returned byte into an 8-bit serializer. The serializer shifts one pixel per clock, most significant bit first.

Lines outside the 256 displayed ones belong to a second agent, such as a drawing engine. A drawing-window flag is high for the whole of every such line, and no frame-memory read is issued while it is high. The frame memory answers a read with one clock of latency. Analog mixing of sync and video is left to the board.

Every timing figure is a parameter, so a much shorter line and field can be built for verification. The defaults give the full picture.

Top module: `vtg_bitmap_timing`

## Requirements
- R1: While reset is high at a clock edge, the next cycle shows hsync, vsync, line_start, draw_win, mem_rd, pix_load and pixel all low and blank high. After reset is released, the first cycle shows position 0 of line 0, and each later cycle advances one position.
- R2: The output position T counts cycles from that first cycle, with column h = T mod CLKS_PER_LINE and line v = (T / CLKS_PER_LINE) mod LINES_PER_FIELD. line_start is high exactly when h = 0.
- R3: hsync is high exactly when h < HSYNC_CLKS (75 clocks by default), so it starts together with line_start.
- R4: vsync is high for the whole of lines v < VSYNC_LINES (lines 0 to 2 by default) and low on all other lines.
- R5: A line is active when ACT_FIRST_LINE <= v < ACT_FIRST_LINE + ACT_LINES (lines 28 to 283 by default). blank is low exactly when the line is active and ACT_START <= h < ACT_START + ACT_PIXELS (columns 200 to 711 by default).
- R6: draw_win is high for the whole of every line that is not active and low for the whole of every active line. mem_rd is never high while draw_win is high.
- R7: On an active line, mem_rd is a one-cycle pulse at h = ACT_START - 2 + 8k for k = 0 .. ACT_PIXELS/8 - 1, and at no other time. With it, mem_addr = (v - ACT_FIRST_LINE) * (ACT_PIXELS/8) + k: the row index fills the upper bits and the byte column the lower bits, so the first read of a field is at address 0.
- R8: pix_load is high in the cycle right after each mem_rd pulse and at no other time. The byte on mem_data in that cycle is loaded into the serializer.
- R9: In the cycle at h = ACT_START + 8k + j (0 <= j < 8) on an active line, pixel equals bit 7 - j of the byte read for column k of that line, so pixels leave most significant bit first.
- R10: pixel is low in every cycle where blank is high, whatever mem_data holds.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock (16 MHz in the target) |
| rst | input | 1 | Synchronous active-high reset |
| mem_data | input | 8 | Frame-memory read data, valid the cycle after mem_rd |
| hsync | output | 1 | Horizontal sync, active high |
| vsync | output | 1 | Vertical sync, active high |
| blank | output | 1 | High outside the displayed pixel window |
| line_start | output | 1 | One-cycle pulse at column 0 of every line |
| draw_win | output | 1 | High on lines where another agent may own the frame memory |
| mem_rd | output | 1 | Frame-memory read strobe |
| mem_addr | output | ADDR_W (14 by default) | Frame-memory byte address, valid with mem_rd |
| pix_load | output | 1 | Parallel-load strobe of the serializer |
| pixel | output | 1 | Serial pixel output, 1 = white |

## Verification
The bound assertions relate the outputs to each other over time. They take two things for granted: the timing parameters keep sync, fetch lead and picture apart (HSYNC_CLKS <= ACT_START - 2), and reset is held for whole clock cycles. The bench respects both. It uses a small legal configuration and changes reset only on falling clock edges. The frame-memory model returns a computed byte one cycle after each read, exactly as the design expects. This means that only blank and load timing decide what reaches the pixel output. The sweep covers more than two full fields plus a restart after a mid-field reset. Every output is compared at every position.

// File: rtl/vtg_pkg.sv
package vtg_pkg;

    // Registered timing outputs that travel together
    typedef struct packed {
        logic hsync;
        logic vsync;
        logic line_start;
        logic blank;
        logic draw_win;
    } vtg_sync_t;

    // Serializer step selection
    typedef enum logic [1:0] {
        SER_CLEAR = 2'd0,
        SER_LOAD  = 2'd1,
        SER_SHIFT = 2'd2
    } vtg_ser_op_t;

    // Value of the sync bundle while reset is applied
    localparam vtg_sync_t SYNC_RESET = '{
        hsync:      1'b0,
        vsync:      1'b0,
        line_start: 1'b0,
        blank:      1'b1,
        draw_win:   1'b0
    };

    // True when lo <= x < lo + n
    function automatic logic in_span(input logic [31:0] x,
                                     input logic [31:0] lo,
                                     input logic [31:0] n);
        return (x >= lo) && (x < lo + n);
    endfunction

    // Clocks between a read strobe and the first pixel of its byte
    localparam int unsigned FETCH_LEAD = 2;

endpackage

// File: rtl/vtg_counters.sv
module vtg_counters #(
    parameter int unsigned CLKS_PER_LINE   = 1024,
    parameter int unsigned LINES_PER_FIELD = 312,
    localparam int unsigned HW = $clog2(CLKS_PER_LINE),
    localparam int unsigned VW = $clog2(LINES_PER_FIELD)
) (
    input  logic          clk,
    input  logic          rst,
    output logic [HW-1:0] hpos,
    output logic [VW-1:0] vpos
);

    localparam logic [HW-1:0] H_LAST = HW'(CLKS_PER_LINE - 1);
    localparam logic [VW-1:0] V_LAST = VW'(LINES_PER_FIELD - 1);

    logic h_wrap;
    logic v_wrap;

    assign h_wrap = (hpos == H_LAST);
    assign v_wrap = (vpos == V_LAST);

    always_ff @(posedge clk) begin
        if (rst) begin
            hpos <= '0;
            vpos <= '0;
        end else begin
            if (h_wrap) begin
                hpos <= '0;
                if (v_wrap) begin
                    vpos <= '0;
                end else begin
                    vpos <= vpos + VW'(1);
                end
            end else begin
                hpos <= hpos + HW'(1);
            end
        end
    end

endmodule

// File: rtl/vtg_decode.sv
module vtg_decode
    import vtg_pkg::*;
#(
    parameter int unsigned CLKS_PER_LINE   = 1024,
    parameter int unsigned LINES_PER_FIELD = 312,
    parameter int unsigned HSYNC_CLKS      = 75,
    parameter int unsigned VSYNC_LINES     = 3,
    parameter int unsigned ACT_START       = 200,
    parameter int unsigned ACT_PIXELS      = 512,
    parameter int unsigned ACT_FIRST_LINE  = 28,
    parameter int unsigned ACT_LINES       = 256,
    localparam int unsigned HW     = $clog2(CLKS_PER_LINE),
    localparam int unsigned VW     = $clog2(LINES_PER_FIELD),
    localparam int unsigned ROW_W  = $clog2(ACT_LINES),
    localparam int unsigned COL_W  = $clog2(ACT_PIXELS / 8),
    localparam int unsigned ADDR_W = ROW_W + COL_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [HW-1:0]     hpos,
    input  logic [VW-1:0]     vpos,
    output vtg_sync_t         sync_q,
    output logic              fetch_q,
    output logic              load_q,
    output logic [ADDR_W-1:0] addr_q
);

    localparam logic [31:0] FETCH_FIRST = 32'(ACT_START - FETCH_LEAD);

    logic [31:0]      h_ext;
    logic [31:0]      v_ext;
    logic [31:0]      fetch_off;
    logic             line_active;
    logic             col_in_window;
    logic             fetch_now;
    logic [ROW_W-1:0] row_idx;
    logic [COL_W-1:0] col_idx;
    vtg_sync_t        sync_d;

    always_comb begin
        h_ext         = 32'(hpos);
        v_ext         = 32'(vpos);
        line_active   = in_span(v_ext, 32'(ACT_FIRST_LINE), 32'(ACT_LINES));
        col_in_window = in_span(h_ext, 32'(ACT_START), 32'(ACT_PIXELS));
        // offset from the first fetch column; wraps to a huge value before it
        fetch_off     = h_ext - FETCH_FIRST;
        fetch_now     = line_active && (fetch_off < 32'(ACT_PIXELS))
                        && (fetch_off[2:0] == 3'd0);
        row_idx       = ROW_W'(v_ext - 32'(ACT_FIRST_LINE));
        col_idx       = COL_W'(fetch_off >> 3);

        sync_d.hsync      = (h_ext < 32'(HSYNC_CLKS));
        sync_d.vsync      = (v_ext < 32'(VSYNC_LINES));
        sync_d.line_start = (h_ext == 32'd0);
        sync_d.blank      = !(line_active && col_in_window);
        sync_d.draw_win   = !line_active;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            sync_q  <= SYNC_RESET;
            fetch_q <= 1'b0;
            load_q  <= 1'b0;
            addr_q  <= '0;
        end else begin
            sync_q  <= sync_d;
            fetch_q <= fetch_now;
            load_q  <= fetch_q;
            if (fetch_now) begin
                addr_q <= {row_idx, col_idx};
            end
        end
    end

endmodule

// File: rtl/vtg_serializer.sv
module vtg_serializer
    import vtg_pkg::*;
#(
    parameter int unsigned BYTE_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              load,
    input  logic              blank,
    input  logic [BYTE_W-1:0] din,
    output logic              pixel
);

    logic [BYTE_W-1:0] shreg;
    vtg_ser_op_t       op;

    always_comb begin
        if (rst) begin
            op = SER_CLEAR;
        end else if (load) begin
            op = SER_LOAD;
        end else begin
            op = SER_SHIFT;
        end
    end

    always_ff @(posedge clk) begin
        case (op)
            SER_CLEAR: shreg <= '0;
            SER_LOAD:  shreg <= din;
            default:   shreg <= {shreg[BYTE_W-2:0], 1'b0};
        endcase
    end

    // Black everywhere outside the displayed window
    assign pixel = shreg[BYTE_W-1] & ~blank;

endmodule

// File: rtl/vtg_bitmap_timing.sv
module vtg_bitmap_timing
    import vtg_pkg::*;
#(
    parameter int unsigned CLKS_PER_LINE   = 1024,
    parameter int unsigned LINES_PER_FIELD = 312,
    parameter int unsigned HSYNC_CLKS      = 75,
    parameter int unsigned VSYNC_LINES     = 3,
    parameter int unsigned ACT_START       = 200,
    parameter int unsigned ACT_PIXELS      = 512,
    parameter int unsigned ACT_FIRST_LINE  = 28,
    parameter int unsigned ACT_LINES       = 256,
    localparam int unsigned ADDR_W = $clog2(ACT_LINES) + $clog2(ACT_PIXELS / 8)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [7:0]        mem_data,
    output logic              hsync,
    output logic              vsync,
    output logic              blank,
    output logic              line_start,
    output logic              draw_win,
    output logic              mem_rd,
    output logic [ADDR_W-1:0] mem_addr,
    output logic              pix_load,
    output logic              pixel
);

    localparam int unsigned HW = $clog2(CLKS_PER_LINE);
    localparam int unsigned VW = $clog2(LINES_PER_FIELD);

    logic [HW-1:0] hpos;
    logic [VW-1:0] vpos;
    vtg_sync_t     sync_q;

    vtg_counters #(
        .CLKS_PER_LINE  (CLKS_PER_LINE),
        .LINES_PER_FIELD(LINES_PER_FIELD)
    ) u_cnt (
        .clk (clk),
        .rst (rst),
        .hpos(hpos),
        .vpos(vpos)
    );

    vtg_decode #(
        .CLKS_PER_LINE  (CLKS_PER_LINE),
        .LINES_PER_FIELD(LINES_PER_FIELD),
        .HSYNC_CLKS     (HSYNC_CLKS),
        .VSYNC_LINES    (VSYNC_LINES),
        .ACT_START      (ACT_START),
        .ACT_PIXELS     (ACT_PIXELS),
        .ACT_FIRST_LINE (ACT_FIRST_LINE),
        .ACT_LINES      (ACT_LINES)
    ) u_dec (
        .clk    (clk),
        .rst    (rst),
        .hpos   (hpos),
        .vpos   (vpos),
        .sync_q (sync_q),
        .fetch_q(mem_rd),
        .load_q (pix_load),
        .addr_q (mem_addr)
    );

    vtg_serializer #(
        .BYTE_W(8)
    ) u_ser (
        .clk  (clk),
        .rst  (rst),
        .load (pix_load),
        .blank(sync_q.blank),
        .din  (mem_data),
        .pixel(pixel)
    );

    assign hsync      = sync_q.hsync;
    assign vsync      = sync_q.vsync;
    assign blank      = sync_q.blank;
    assign line_start = sync_q.line_start;
    assign draw_win   = sync_q.draw_win;

endmodule

// File: rtl/vtg_checker.sv
module vtg_checker (
    input logic clk,
    input logic rst,
    input logic hsync,
    input logic vsync,
    input logic blank,
    input logic line_start,
    input logic draw_win,
    input logic mem_rd,
    input logic pix_load,
    input logic pixel
);

    // R2
    line_start_single_chk: assert property (@(posedge clk) disable iff (rst)
        line_start |=> !line_start);

    // R3
    hsync_at_start_chk: assert property (@(posedge clk) disable iff (rst)
        line_start |-> hsync);

    // R4
    vsync_line_stable_chk: assert property (@(posedge clk) disable iff (rst)
        !line_start |-> $stable(vsync));

    // R5
    blank_in_sync_chk: assert property (@(posedge clk) disable iff (rst)
        hsync |-> blank);

    // R6
    draw_line_stable_chk: assert property (@(posedge clk) disable iff (rst)
        !line_start |-> $stable(draw_win));

    // R6
    draw_no_read_chk: assert property (@(posedge clk) disable iff (rst)
        draw_win |-> (!mem_rd && blank));

    // R8
    load_follows_read_chk: assert property (@(posedge clk) disable iff (rst)
        mem_rd |=> pix_load);

    // R8
    load_has_read_chk: assert property (@(posedge clk) disable iff (rst)
        pix_load |-> $past(mem_rd));

    // R10
    pixel_black_chk: assert property (@(posedge clk) disable iff (rst)
        blank |-> !pixel);

endmodule

bind vtg_bitmap_timing vtg_checker u_vtg_chk (
    .clk       (clk),
    .rst       (rst),
    .hsync     (hsync),
    .vsync     (vsync),
    .blank     (blank),
    .line_start(line_start),
    .draw_win  (draw_win),
    .mem_rd    (mem_rd),
    .pix_load  (pix_load),
    .pixel     (pixel)
);

// File: tb/tb_vtg_bitmap_timing.sv
module tb_vtg_bitmap_timing;

    localparam int L   = 64;
    localparam int F   = 20;
    localparam int HS  = 5;
    localparam int VS  = 2;
    localparam int AS  = 16;
    localparam int PIX = 32;
    localparam int AF  = 4;
    localparam int AL  = 8;
    localparam int BYTES = PIX / 8;
    localparam int AW  = $clog2(AL) + $clog2(BYTES);

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic [7:0]    mem_q = 8'h00;
    logic          hsync, vsync, blank, line_start, draw_win;
    logic          mem_rd, pix_load, pixel;
    logic [AW-1:0] mem_addr;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    always #5 clk = ~clk;

    vtg_bitmap_timing #(
        .CLKS_PER_LINE  (L),
        .LINES_PER_FIELD(F),
        .HSYNC_CLKS     (HS),
        .VSYNC_LINES    (VS),
        .ACT_START      (AS),
        .ACT_PIXELS     (PIX),
        .ACT_FIRST_LINE (AF),
        .ACT_LINES      (AL)
    ) dut (
        .clk       (clk),
        .rst       (rst),
        .mem_data  (mem_q),
        .hsync     (hsync),
        .vsync     (vsync),
        .blank     (blank),
        .line_start(line_start),
        .draw_win  (draw_win),
        .mem_rd    (mem_rd),
        .mem_addr  (mem_addr),
        .pix_load  (pix_load),
        .pixel     (pixel)
    );

    function automatic logic [7:0] pat(input int a);
        return 8'((a * 73 + 29) ^ (a << 3));
    endfunction

    // Frame memory: one cycle of read latency
    always @(posedge clk) begin
        if (mem_rd) mem_q <= pat(int'(mem_addr));
    end

    task automatic chk(input string req, input string what,
                       input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    function automatic bit line_act(input int t);
        int v = (t / L) % F;
        return (v >= AF) && (v < AF + AL);
    endfunction

    function automatic bit fetch_at(input int t);
        int h = t % L;
        int fo = h - (AS - 2);
        return line_act(t) && (fo >= 0) && (fo < PIX) && (fo % 8 == 0);
    endfunction

    task automatic check_reset();
        chk("R1", "hsync", int'(hsync), 0);
        chk("R1", "vsync", int'(vsync), 0);
        chk("R1", "line_start", int'(line_start), 0);
        chk("R1", "draw_win", int'(draw_win), 0);
        chk("R1", "mem_rd", int'(mem_rd), 0);
        chk("R1", "pix_load", int'(pix_load), 0);
        chk("R1", "pixel", int'(pixel), 0);
        chk("R1", "blank", int'(blank), 1);
    endtask

    task automatic check_slot(input int t);
        int h = t % L;
        int v = (t / L) % F;
        bit act = line_act(t);
        bit win = act && (h >= AS) && (h < AS + PIX);
        int ep = 0;
        chk("R2", "line_start", int'(line_start), int'(h == 0));
        chk("R3", "hsync", int'(hsync), int'(h < HS));
        chk("R4", "vsync", int'(vsync), int'(v < VS));
        chk("R5", "blank", int'(blank), int'(!win));
        chk("R6", "draw_win", int'(draw_win), int'(!act));
        chk("R7", "mem_rd", int'(mem_rd), int'(fetch_at(t)));
        if (fetch_at(t)) begin
            chk("R7", "mem_addr", int'(mem_addr),
                (v - AF) * BYTES + (h - (AS - 2)) / 8);
        end
        chk("R8", "pix_load", int'(pix_load), int'(t > 0 && fetch_at(t - 1)));
        if (win) begin
            int j = h - AS;
            logic [7:0] b = pat((v - AF) * BYTES + j / 8);
            ep = int'(b[7 - (j % 8)]);
            chk("R9", "pixel", int'(pixel), ep);
        end else begin
            chk("R10", "pixel", int'(pixel), 0);
        end
    endtask

    task automatic run_slots(input int n);
        for (int t = 0; t < n; t++) begin
            @(posedge clk);
            @(negedge clk);
            check_slot(t);
        end
    endtask

    initial begin
        rst = 1'b1;
        repeat (3) @(posedge clk);
        @(negedge clk);
        check_reset();
        rst = 1'b0;
        run_slots(2 * L * F + 300);

        // Reset in the middle of a field, then restart from position 0
        @(negedge clk);
        rst = 1'b1;
        @(posedge clk);
        @(negedge clk);
        check_reset();
        @(posedge clk);
        @(negedge clk);
        check_reset();
        rst = 1'b0;
        run_slots(L * (AF + AL + 2));

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule